// File: doc/BRIEF.md
# Bus-Matching Width Adapter

This block sits at one port of a buffer and converts between the buffer's 36-bit word and a narrower 18-bit or 9-bit word at that port. On the wide-to-narrow side it takes one 36-bit word and hands it out as a sequence of two or four narrow words. On the narrow-to-wide side it collects two or four narrow words and hands out one assembled 36-bit word. It also supports a straight 36-to-36 pass-through.

Both sides use a valid/ready handshake. The width pairing and the byte order are set by four configuration pins. These pins are sampled only while the synchronous reset is high.

Inside a 36-bit word the narrow lanes sit at fixed positions. The 18-bit lanes are at [35:18] and [17:0]. The 9-bit lanes are at [35:27], [26:18], [17:9] and [8:0]. The byte order decides which lane travels first.

Top module: `bus_width_adapter`

## Requirements
- R1: The pins sampled at reset select the pairing (input width / output width). With `cfg_bm`=0 the pairing is 36/36 whatever `cfg_iw` and `cfg_ow` are. With `cfg_bm`=1 the encodings of (`cfg_iw`,`cfg_ow`) are: (0,0)=36/18, (0,1)=36/9, (1,0)=18/36, (1,1)=9/36.
- R2: The configuration pins are sampled on every clock edge while `rst` is 1 and are ignored while `rst` is 0.
- R3: The first edge with `rst` high clears all state. After reset, `out_valid` is 0 and `in_ready` is 1. Any word that was partly split or partly packed is discarded.
- R4: When splitting with `cfg_big`=1, the most significant lane of the wide word is delivered first and the lanes then go down in order to the least significant.
- R5: When splitting with `cfg_big`=0, the least significant lane is delivered first and the lanes then go up in order. In 36/36 mode `cfg_big` has no effect.
- R6: When packing, a 36-bit word is presented only after all 2 or 4 narrow words have been accepted. With `cfg_big`=1 the first narrow word lands in the most significant lane. With `cfg_big`=0 it lands in the least significant lane.
- R7: A narrow input word is taken from the low 18 or 9 bits of `in_data`, and the upper bits are ignored. A narrow output word appears in the low bits of `out_data`, and the upper bits are zero.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold. Words are neither lost nor duplicated, and their order is kept.
- R9: In 36/36 mode with `out_ready` held at 1, `in_ready` stays at 1, so one word passes per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; the configuration is sampled while it is high |
| cfg_bm | input | 1 | Enables bus matching |
| cfg_iw | input | 1 | Input-width select |
| cfg_ow | input | 1 | Output-width select |
| cfg_big | input | 1 | 1 = most significant lane first, 0 = least significant first |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word accepted when high together with in_valid |
| in_data | input | 36 | Input word; narrow words use the low bits |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Consumer takes the output word |
| out_data | output | 36 | Output word; narrow words use the low bits |

## Verification
A wrong lane counter or a wrong lane-position decode shows up at `out_data` on the next transfer. In split mode the wrong narrow slice appears at once. In pack mode a lane is misplaced in the 36-bit word that is emitted two or four accepts later. A stale partial word left over from reset corrupts the first word after reset, so the bench resets halfway through both a split and a pack sequence. A configuration register that follows the pins outside reset changes the lane sequence within one cycle, so the bench toggles the pins throughout traffic.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int WIDE_W = 36;

    typedef enum logic [2:0] {
        PAIR_36_36,
        PAIR_36_18,
        PAIR_36_9,
        PAIR_18_36,
        PAIR_9_36
    } pair_e;

    typedef enum logic [1:0] {
        LANE_FULL,
        LANE_HALF,
        LANE_QUARTER
    } lane_e;

    typedef struct packed {
        pair_e pair;
        logic  big;
    } cfg_t;

    function automatic pair_e decode_pair(logic bm, logic iw, logic ow);
        pair_e p;
        if (!bm) begin
            p = PAIR_36_36;
        end else begin
            case ({iw, ow})
                2'b00:   p = PAIR_36_18;
                2'b01:   p = PAIR_36_9;
                2'b10:   p = PAIR_18_36;
                default: p = PAIR_9_36;
            endcase
        end
        return p;
    endfunction

    function automatic logic is_pack(pair_e p);
        return (p == PAIR_18_36) || (p == PAIR_9_36);
    endfunction

    function automatic lane_e lane_of(pair_e p);
        lane_e l;
        case (p)
            PAIR_36_18, PAIR_18_36: l = LANE_HALF;
            PAIR_36_9, PAIR_9_36:   l = LANE_QUARTER;
            default:                l = LANE_FULL;
        endcase
        return l;
    endfunction

    function automatic logic [2:0] lane_count(lane_e l);
        logic [2:0] n;
        case (l)
            LANE_HALF:    n = 3'd2;
            LANE_QUARTER: n = 3'd4;
            default:      n = 3'd1;
        endcase
        return n;
    endfunction

    // Physical lane (0 = least significant) for the seq-th narrow word.
    function automatic logic [1:0] lane_pos(logic [1:0] seq, logic [2:0] cnt, logic big);
        logic [2:0] rev;
        rev = cnt - 3'd1 - {1'b0, seq};
        return big ? rev[1:0] : seq;
    endfunction

endpackage

// File: rtl/bwa_cfg.sv
module bwa_cfg
    import bwa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bm,
    input  logic iw,
    input  logic ow,
    input  logic big,
    output cfg_t cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.pair <= decode_pair(bm, iw, ow);
            cfg_q.big  <= big;
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/bwa_split.sv
module bwa_split
    import bwa_pkg::*;
#(
    parameter int W = WIDE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_e        lw,
    input  logic         big,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    localparam int H = W / 2;
    localparam int Q = W / 4;

    logic [W-1:0] hold_q;
    logic         busy_q;
    logic [1:0]   seq_q;
    logic [2:0]   cnt;
    logic [1:0]   pos;
    logic         last;
    logic [H-1:0] half_l [2];
    logic [Q-1:0] quar_l [4];

    for (genvar g = 0; g < 2; g++) begin : g_half
        assign half_l[g] = hold_q[g*H +: H];
    end
    for (genvar g = 0; g < 4; g++) begin : g_quar
        assign quar_l[g] = hold_q[g*Q +: Q];
    end

    assign cnt  = lane_count(lw);
    assign pos  = lane_pos(seq_q, cnt, big);
    assign last = ({1'b0, seq_q} == cnt - 3'd1);

    assign out_valid = busy_q;
    assign in_ready  = !busy_q || (out_ready && last);

    always_comb begin
        case (lw)
            LANE_HALF:    out_data = {{(W-H){1'b0}}, half_l[pos[0]]};
            LANE_QUARTER: out_data = {{(W-Q){1'b0}}, quar_l[pos]};
            default:      out_data = hold_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            seq_q  <= '0;
            hold_q <= '0;
        end else begin
            if (busy_q && out_ready) begin
                if (last) begin
                    busy_q <= 1'b0;
                    seq_q  <= '0;
                end else begin
                    seq_q <= seq_q + 2'd1;
                end
            end
            if (in_valid && in_ready) begin
                hold_q <= in_data;
                busy_q <= 1'b1;
                seq_q  <= '0;
            end
        end
    end
endmodule

// File: rtl/bwa_pack.sv
module bwa_pack
    import bwa_pkg::*;
#(
    parameter int W = WIDE_W
) (
    input  logic           clk,
    input  logic           rst,
    input  lane_e          lw,
    input  logic           big,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [W/2-1:0] in_data,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [W-1:0]   out_data
);
    localparam int H = W / 2;
    localparam int Q = W / 4;

    logic [W-1:0] acc_q, acc_d;
    logic         full_q;
    logic [1:0]   seq_q;
    logic [2:0]   cnt;
    logic [1:0]   pos;
    logic         last;
    logic         take;

    assign cnt  = lane_count(lw);
    assign pos  = lane_pos(seq_q, cnt, big);
    assign last = ({1'b0, seq_q} == cnt - 3'd1);

    assign in_ready  = !full_q || out_ready;
    assign take      = in_valid && in_ready;
    assign out_valid = full_q;
    assign out_data  = acc_q;

    always_comb begin
        acc_d = acc_q;
        case (lw)
            LANE_HALF:    acc_d[int'(pos[0])*H +: H] = in_data;
            LANE_QUARTER: acc_d[int'(pos)*Q +: Q]    = in_data[Q-1:0];
            default:      acc_d = acc_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            full_q <= 1'b0;
            seq_q  <= '0;
        end else begin
            if (full_q && out_ready) begin
                full_q <= 1'b0;
            end
            if (take) begin
                acc_q <= acc_d;
                if (last) begin
                    full_q <= 1'b1;
                    seq_q  <= '0;
                end else begin
                    seq_q <= seq_q + 2'd1;
                end
            end
        end
    end
endmodule

// File: rtl/bus_width_adapter.sv
module bus_width_adapter
    import bwa_pkg::*;
#(
    parameter int W = WIDE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_bm,
    input  logic         cfg_iw,
    input  logic         cfg_ow,
    input  logic         cfg_big,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);
    cfg_t         cfg_q;
    logic         pack_mode;
    lane_e        lane_w;

    logic         sp_in_valid, sp_in_ready, sp_out_valid, sp_out_ready;
    logic [W-1:0] sp_out_data;
    logic         pk_in_valid, pk_in_ready, pk_out_valid, pk_out_ready;
    logic [W-1:0] pk_out_data;

    bwa_cfg u_cfg (
        .clk (clk),
        .rst (rst),
        .bm  (cfg_bm),
        .iw  (cfg_iw),
        .ow  (cfg_ow),
        .big (cfg_big),
        .cfg (cfg_q)
    );

    assign pack_mode = is_pack(cfg_q.pair);
    assign lane_w    = lane_of(cfg_q.pair);

    assign sp_in_valid  = in_valid  && !pack_mode;
    assign sp_out_ready = out_ready && !pack_mode;
    assign pk_in_valid  = in_valid  && pack_mode;
    assign pk_out_ready = out_ready && pack_mode;

    bwa_split #(.W(W)) u_split (
        .clk       (clk),
        .rst       (rst),
        .lw        (lane_w),
        .big       (cfg_q.big),
        .in_valid  (sp_in_valid),
        .in_ready  (sp_in_ready),
        .in_data   (in_data),
        .out_valid (sp_out_valid),
        .out_ready (sp_out_ready),
        .out_data  (sp_out_data)
    );

    bwa_pack #(.W(W)) u_pack (
        .clk       (clk),
        .rst       (rst),
        .lw        (lane_w),
        .big       (cfg_q.big),
        .in_valid  (pk_in_valid),
        .in_ready  (pk_in_ready),
        .in_data   (in_data[W/2-1:0]),
        .out_valid (pk_out_valid),
        .out_ready (pk_out_ready),
        .out_data  (pk_out_data)
    );

    assign in_ready  = pack_mode ? pk_in_ready  : sp_in_ready;
    assign out_valid = pack_mode ? pk_out_valid : sp_out_valid;
    assign out_data  = pack_mode ? pk_out_data  : sp_out_data;
endmodule

// File: rtl/bwa_checker.sv
module bwa_checker
    import bwa_pkg::*;
#(
    parameter int W = WIDE_W
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         in_ready,
    input logic         out_valid,
    input logic         out_ready,
    input logic [W-1:0] out_data,
    input pair_e        pair
);
    localparam int H = W / 2;
    localparam int Q = W / 4;

    a_r3_reset_idle: assert property (@(posedge clk) $past(rst) |-> !out_valid);

    a_r8_out_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(pair));

    a_r7_half_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pair == PAIR_36_18) |-> (out_data[W-1:H] == '0));

    a_r7_quarter_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && pair == PAIR_36_9) |-> (out_data[W-1:Q] == '0));

    a_r6_emit_after_accept: assert property (@(posedge clk) disable iff (rst)
        $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind bus_width_adapter bwa_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .pair      (cfg_q.pair)
);

// File: tb/tb_bus_width_adapter.sv
module tb_bus_width_adapter;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bm = 1'b0, cfg_iw = 1'b0, cfg_ow = 1'b0, cfg_big = 1'b0;
    logic        in_valid = 1'b0, out_ready = 1'b0;
    logic [35:0] in_data = '0;
    logic        in_ready, out_valid;
    logic [35:0] out_data;

    int errors = 0;
    int checks = 0;

    // reference model state
    int          win, wout;
    logic        big_m;
    logic [35:0] exq[$];
    logic [35:0] pacc;
    int          pcnt;
    logic        prev_hold;
    logic [35:0] prev_data;

    always #10 clk = ~clk;

    bus_width_adapter dut (
        .clk(clk), .rst(rst),
        .cfg_bm(cfg_bm), .cfg_iw(cfg_iw), .cfg_ow(cfg_ow), .cfg_big(cfg_big),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input logic ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag();
        if (win < 36) return "R6 R7 R1";
        if (wout == 36) return "R1 R2";
        return big_m ? "R4 R7 R2" : "R5 R7 R2";
    endfunction

    function automatic logic [35:0] mask(input int w);
        return (w == 36) ? 36'hF_FFFF_FFFF : ((36'd1 << w) - 36'd1);
    endfunction

    task automatic model_accept(input logic [35:0] d);
        int n, lane;
        if (win == 36) begin
            n = 36 / wout;
            for (int k = 0; k < n; k++) begin
                lane = big_m ? n - 1 - k : k;
                exq.push_back((d >> (lane * wout)) & mask(wout));
            end
        end else begin
            n = 36 / win;
            lane = big_m ? n - 1 - pcnt : pcnt;
            pacc = pacc | ((d & mask(win)) << (lane * win));
            pcnt++;
            if (pcnt == n) begin
                exq.push_back(pacc);
                pacc = '0;
                pcnt = 0;
            end
        end
    endtask

    task automatic do_reset(input logic bm, input logic iw, input logic ow, input logic be);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        cfg_bm = bm; cfg_iw = iw; cfg_ow = ow; cfg_big = be;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        if (!bm) begin win = 36; wout = 36; end
        else case ({iw, ow})
            2'b00: begin win = 36; wout = 18; end
            2'b01: begin win = 36; wout = 9;  end
            2'b10: begin win = 18; wout = 36; end
            default: begin win = 9; wout = 36; end
        endcase
        big_m = be;
        exq.delete();
        pacc = '0; pcnt = 0; prev_hold = 1'b0;
        #2;
        check(out_valid == 1'b0, "R3 out_valid after reset", {35'd0, out_valid}, 36'd0);
        check(in_ready == 1'b1, "R3 in_ready after reset", {35'd0, in_ready}, 36'd1);
    endtask

    // one cycle: drive at negedge, sample 2 ns later, model the coming edge
    task automatic step(input logic iv, input logic ordy, input logic [35:0] d, input logic scramble);
        @(negedge clk);
        in_valid = iv; out_ready = ordy; in_data = d;
        if (scramble) begin
            cfg_bm = $urandom(); cfg_iw = $urandom(); cfg_ow = $urandom(); cfg_big = $urandom();
        end
        #2;
        if (prev_hold)
            check(out_valid && out_data == prev_data, "R8 hold under backpressure", out_data, prev_data);
        if (out_valid) begin
            if (exq.size() == 0) begin
                check(1'b0, "R8 unexpected output", out_data, 36'd0);
            end else begin
                check(out_data == exq[0], tag(), out_data, exq[0]);
                if (ordy) void'(exq.pop_front());
            end
        end
        if (win == 36 && wout == 36 && ordy)
            check(in_ready == 1'b1, "R9 pass-through throughput", {35'd0, in_ready}, 36'd1);
        prev_hold = out_valid && !ordy;
        prev_data = out_data;
        if (iv && in_ready) model_accept(d);
    endtask

    task automatic traffic(input int cycles, input int vpct, input int rpct);
        logic [63:0] r;
        for (int i = 0; i < cycles; i++) begin
            r = {$urandom(), $urandom()};
            step(($urandom() % 100) < vpct, ($urandom() % 100) < rpct, r[35:0], 1'b1);
        end
        for (int i = 0; i < 12; i++) step(1'b0, 1'b1, '0, 1'b1);
        check(exq.size() == 0, "R8 all words delivered", 36'(exq.size()), 36'd0);
    endtask

    task automatic run_mode(input logic bm, input logic iw, input logic ow, input logic be);
        do_reset(bm, iw, ow, be);
        traffic(300, 70, 60);
        traffic(60, 100, 100);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        win = 36; wout = 36; big_m = 1'b0; pacc = '0; pcnt = 0;
        prev_hold = 1'b0; prev_data = '0;

        // R1: pass-through even with iw/ow set, R9 at full rate
        run_mode(1'b0, 1'b1, 1'b1, 1'b1);
        run_mode(1'b1, 1'b0, 1'b0, 1'b1);
        run_mode(1'b1, 1'b0, 1'b0, 1'b0);
        run_mode(1'b1, 1'b0, 1'b1, 1'b1);
        run_mode(1'b1, 1'b0, 1'b1, 1'b0);
        run_mode(1'b1, 1'b1, 1'b0, 1'b1);
        run_mode(1'b1, 1'b1, 1'b0, 1'b0);
        run_mode(1'b1, 1'b1, 1'b1, 1'b1);
        run_mode(1'b1, 1'b1, 1'b1, 1'b0);

        // R4 directed: 36/9 big-endian, first lane is bits [35:27]
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        step(1'b1, 1'b0, 36'h1_2345_6789, 1'b0);
        step(1'b0, 1'b0, '0, 1'b0);
        check(out_data == 36'h1_2345_6789 >> 27, "R4 first lane msb", out_data, 36'h1_2345_6789 >> 27);
        // R3: split halfway, then reset discards the rest
        step(1'b0, 1'b1, '0, 1'b0);
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        traffic(80, 70, 70);

        // R3: pack halfway in 9/36 little-endian, reset, stale lanes must not leak
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 36'h0_0000_01AA, 1'b0);
        step(1'b1, 1'b1, 36'h0_0000_0155, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        check(out_valid == 1'b0, "R6 no early emit", {35'd0, out_valid}, 36'd0);
        do_reset(1'b1, 1'b1, 1'b1, 1'b0);
        traffic(80, 70, 70);

        // R6 directed: 18/36 big-endian, upper input bits ignored (R7)
        do_reset(1'b1, 1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 36'hF_C000_1111, 1'b0);
        step(1'b1, 1'b1, 36'hA_8000_2222, 1'b0);
        step(1'b0, 1'b1, '0, 1'b0);
        check(out_data == 36'h0_4444_2222, "R6 R7 big pack", out_data, 36'h0_4444_2222);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule